// File: doc/BRIEF.md
# Keyboard Scan-Code Prefix and Shift Decoder

This block sits behind a serial keyboard byte receiver. It takes one 8-bit scan-code byte (code set 2) per strobe. It then turns the stream into one record per key.

The two prefix bytes are absorbed into held flags rather than passed on. The break prefix is 0xF0 and the extended prefix is 0xE0. The next real key code takes these flags as its released and extended indicators, and then the flags are cleared.

Both shift keys are tracked, and the combined status is visible at all times. Each key record holds the following:
- the raw code;
- the two indicators;
- the shift status;
- an ASCII character, which is uppercase or shifted while either shift key is down.

A consumer takes records through a ready/read handshake. A build-time parameter can hide shift-key codes from the record stream. The shift status output still follows those keys.

Top module: `kbd_scan_decoder`

## Requirements
- R1: Synchronous reset clears the held prefix flags, both shift states, `key_ready`, `key_code`, `key_ext`, `key_rel` and `key_ascii`, so all of them read 0 after reset.
- R2: A byte of 0xE0 raises no record. The next non-prefix byte comes out with `key_ext`=1, and the key code after that has `key_ext`=0 unless a new 0xE0 precedes it.
- R3: A byte of 0xF0 raises no record. The next non-prefix byte comes out with `key_rel`=1, and the key code after that has `key_rel`=0 unless a new 0xF0 precedes it.
- R4: The sequence 0xE0 0xF0 followed by a code gives one record with both `key_ext`=1 and `key_rel`=1.
- R5: Codes 0x12 (left shift) and 0x59 (right shift) without an extended prefix set their own shift state on make and clear it when they arrive with the break prefix. `shift_on` is the OR of the two states, and an extended 0x12 changes neither state.
- R6: With shift inactive, keys map to ASCII as follows:
  - letter keys give lowercase letters, for example 0x1C gives 0x61;
  - digit keys give digits, for example 0x16 gives 0x31;
  - 0x5A gives 0x0D, 0x0D gives 0x09, 0x29 gives 0x20 and 0x4E gives 0x2D.
- R7: With shift active, letters map to uppercase and digit or punctuation keys map to their shifted symbols, for example 0x1C gives 0x41, 0x16 gives 0x21, 0x4E gives 0x5F and 0x15 gives 0x51. The shift state used is the one in effect before the key byte arrives.
- R8: Any record with `key_ext`=1, and any code with no printable, Enter or Tab meaning (such as 0x07 or a shift code), carries `key_ascii`=0x00.
- R9: With `HIDE_SHIFT`=1, non-extended shift codes raise no record but still update `shift_on` and still clear the held prefix flags. With `HIDE_SHIFT`=0, those codes come out as normal records.
- R10: `key_ready` stays high, with the record unchanged, until `key_read` is pulsed. A read alone drops `key_ready` on the next cycle. A new record overwrites the held one and keeps `key_ready` high, even in the same cycle as a read.
- R11: A record is visible one clock after the edge that samples its key byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe marking a received scan-code byte |
| byte_data | input | 8 | Received scan-code byte |
| key_read | input | 1 | Consumer pulse that takes the held record |
| key_ready | output | 1 | A key record is held |
| key_code | output | 8 | Scan code of the held record |
| key_ext | output | 1 | Held record was preceded by the extended prefix |
| key_rel | output | 1 | Held record was preceded by the break prefix |
| key_ascii | output | 8 | ASCII equivalent of the held record, 0x00 if none |
| shift_on | output | 1 | Either shift key is currently down |

## Verification
The hardest case to set up is a hidden shift code that must still clear the held break flag. From the ports it looks like nothing happened. The only evidence appears on the next, unrelated key.

The stimulus sends break plus left shift while no shift is held, and then sends a letter. It checks that the letter's record has a clear release indicator.

Two instances with opposite `HIDE_SHIFT` settings share the same byte stream. This lets every shift sequence be checked both as a hidden status change and as a visible record. Interleaving the two shift keys' make and break codes shows that releasing one key keeps uppercase output while the other is still held.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    localparam int CODE_W = 8;
    localparam int CHAR_W = 8;

    localparam logic [CODE_W-1:0] SC_EXT_PREFIX   = 8'hE0;
    localparam logic [CODE_W-1:0] SC_BREAK_PREFIX = 8'hF0;
    localparam logic [CODE_W-1:0] SC_SHIFT_LEFT   = 8'h12;
    localparam logic [CODE_W-1:0] SC_SHIFT_RIGHT  = 8'h59;

    typedef struct packed {
        logic ext;
        logic rel;
        logic shift_l;
        logic shift_r;
    } track_t;

    typedef struct packed {
        logic              ready;
        logic [CODE_W-1:0] code;
        logic              ext;
        logic              rel;
        logic [CHAR_W-1:0] ascii;
    } keyout_t;

endpackage

// File: rtl/kbd_prefix_track.sv
module kbd_prefix_track
    import kbd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [CODE_W-1:0] byte_data,
    output logic              key_evt,
    output logic              key_ext,
    output logic              key_rel,
    output logic              key_is_shift,
    output logic              shift_active
);

    track_t trk_d, trk_q;
    logic   is_prefix;
    logic   is_left;
    logic   is_right;

    always_comb begin
        is_prefix    = (byte_data == SC_EXT_PREFIX) || (byte_data == SC_BREAK_PREFIX);
        is_left      = (byte_data == SC_SHIFT_LEFT);
        is_right     = (byte_data == SC_SHIFT_RIGHT);
        key_evt      = byte_valid && !is_prefix;
        key_ext      = trk_q.ext;
        key_rel      = trk_q.rel;
        key_is_shift = key_evt && !trk_q.ext && (is_left || is_right);
        shift_active = trk_q.shift_l || trk_q.shift_r;

        trk_d = trk_q;
        if (byte_valid) begin
            if (byte_data == SC_EXT_PREFIX) begin
                trk_d.ext = 1'b1;
            end else if (byte_data == SC_BREAK_PREFIX) begin
                trk_d.rel = 1'b1;
            end else begin
                trk_d.ext = 1'b0;
                trk_d.rel = 1'b0;
                if (!trk_q.ext && is_left)  trk_d.shift_l = !trk_q.rel;
                if (!trk_q.ext && is_right) trk_d.shift_r = !trk_q.rel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trk_q <= '0;
        else     trk_q <= trk_d;
    end

endmodule

// File: rtl/kbd_ascii_map.sv
module kbd_ascii_map
    import kbd_scan_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              shifted,
    input  logic              ext,
    output logic [CHAR_W-1:0] ascii
);

    logic [2*CHAR_W-1:0] pair;

    always_comb begin
        case (code)
            8'h1C: pair = "aA";
            8'h32: pair = "bB";
            8'h21: pair = "cC";
            8'h23: pair = "dD";
            8'h24: pair = "eE";
            8'h2B: pair = "fF";
            8'h34: pair = "gG";
            8'h33: pair = "hH";
            8'h43: pair = "iI";
            8'h3B: pair = "jJ";
            8'h42: pair = "kK";
            8'h4B: pair = "lL";
            8'h3A: pair = "mM";
            8'h31: pair = "nN";
            8'h44: pair = "oO";
            8'h4D: pair = "pP";
            8'h15: pair = "qQ";
            8'h2D: pair = "rR";
            8'h1B: pair = "sS";
            8'h2C: pair = "tT";
            8'h3C: pair = "uU";
            8'h2A: pair = "vV";
            8'h1D: pair = "wW";
            8'h22: pair = "xX";
            8'h35: pair = "yY";
            8'h1A: pair = "zZ";
            8'h16: pair = "1!";
            8'h1E: pair = "2@";
            8'h26: pair = "3#";
            8'h25: pair = "4$";
            8'h2E: pair = "5%";
            8'h36: pair = "6^";
            8'h3D: pair = "7&";
            8'h3E: pair = "8*";
            8'h46: pair = "9(";
            8'h45: pair = "0)";
            8'h4E: pair = "-_";
            8'h55: pair = "=+";
            8'h54: pair = "[{";
            8'h5B: pair = "]}";
            8'h5D: pair = "\\|";
            8'h4C: pair = ";:";
            8'h52: pair = "'\"";
            8'h0E: pair = "`~";
            8'h41: pair = ",<";
            8'h49: pair = ".>";
            8'h4A: pair = "/?";
            8'h29: pair = "  ";
            8'h5A: pair = 16'h0D0D;
            8'h0D: pair = 16'h0909;
            default: pair = '0;
        endcase

        if (ext)          ascii = '0;
        else if (shifted) ascii = pair[CHAR_W-1:0];
        else              ascii = pair[2*CHAR_W-1:CHAR_W];
    end

endmodule

// File: rtl/kbd_scan_decoder.sv
module kbd_scan_decoder
    import kbd_scan_pkg::*;
#(
    parameter bit HIDE_SHIFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [CODE_W-1:0] byte_data,
    input  logic              key_read,
    output logic              key_ready,
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_rel,
    output logic [CHAR_W-1:0] key_ascii,
    output logic              shift_on
);

    logic              evt;
    logic              evt_ext;
    logic              evt_rel;
    logic              evt_shift;
    logic              shift_pre;
    logic              strobe;
    logic [CHAR_W-1:0] evt_ascii;
    keyout_t           out_d, out_q;

    kbd_prefix_track i_track (
        .clk          (clk),
        .rst          (rst),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .key_evt      (evt),
        .key_ext      (evt_ext),
        .key_rel      (evt_rel),
        .key_is_shift (evt_shift),
        .shift_active (shift_pre)
    );

    kbd_ascii_map i_map (
        .code    (byte_data),
        .shifted (shift_pre),
        .ext     (evt_ext),
        .ascii   (evt_ascii)
    );

    generate
        if (HIDE_SHIFT) begin : g_hide
            assign strobe = evt && !evt_shift;
        end else begin : g_pass
            assign strobe = evt;
        end
    endgenerate

    always_comb begin
        out_d = out_q;
        if (strobe) begin
            out_d.ready = 1'b1;
            out_d.code  = byte_data;
            out_d.ext   = evt_ext;
            out_d.rel   = evt_rel;
            out_d.ascii = evt_ascii;
        end else if (key_read) begin
            out_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign key_ready = out_q.ready;
    assign key_code  = out_q.code;
    assign key_ext   = out_q.ext;
    assign key_rel   = out_q.rel;
    assign key_ascii = out_q.ascii;
    assign shift_on  = shift_pre;

endmodule

// File: rtl/kbd_scan_decoder_chk.sv
module kbd_scan_decoder_chk #(
    parameter bit HIDE_SHIFT = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       key_read,
    input logic       key_ready,
    input logic [7:0] key_code,
    input logic       key_ext,
    input logic [7:0] key_ascii,
    input logic       shift_on
);

    assert_prefix_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (!key_ready && byte_valid && (byte_data == 8'hE0 || byte_data == 8'hF0)) |=> !key_ready);

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (key_read && !byte_valid) |=> !key_ready);

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (key_ready && !key_read) |=> key_ready);

    assert_record_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (key_ready && !byte_valid) |=> ($stable(key_code) && $stable(key_ascii)));

    assert_shift_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_on) |-> $past(byte_valid && (byte_data == 8'h12 || byte_data == 8'h59)));

    assert_shift_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_on) |-> $past(byte_valid));

    assert_ext_no_ascii_R8: assert property (@(posedge clk) disable iff (rst)
        (key_ready && key_ext) |-> (key_ascii == 8'h00));

    assert_hidden_shift_R9: assert property (@(posedge clk) disable iff (rst)
        (HIDE_SHIFT && key_ready && !key_ext) |-> (key_code != 8'h12 && key_code != 8'h59));

endmodule

bind kbd_scan_decoder kbd_scan_decoder_chk #(.HIDE_SHIFT(HIDE_SHIFT)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .key_read   (key_read),
    .key_ready  (key_ready),
    .key_code   (key_code),
    .key_ext    (key_ext),
    .key_ascii  (key_ascii),
    .shift_on   (shift_on)
);

// File: tb/test_kbd_scan_decoder.sv
`timescale 1ns/1ps
module test_kbd_scan_decoder;

    typedef struct packed {
        logic [7:0] code;
        logic       ext;
        logic       rel;
        logic       shift;
        logic [7:0] ascii;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic key_read = 1'b0;
    logic mon_en = 1'b0;

    logic       rdy_h, ext_h, rel_h, sh_h;
    logic [7:0] code_h, asc_h;
    logic       rdy_p, ext_p, rel_p, sh_p;
    logic [7:0] code_p, asc_p;

    int n_checks = 0;
    int n_fail = 0;

    item_t qh[$];
    item_t qp[$];
    string th[$];
    string tp[$];

    always #10 clk = ~clk;

    kbd_scan_decoder #(.HIDE_SHIFT(1'b1)) i_kbd_scan_decoder (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .key_read(key_read), .key_ready(rdy_h), .key_code(code_h), .key_ext(ext_h),
        .key_rel(rel_h), .key_ascii(asc_h), .shift_on(sh_h));

    kbd_scan_decoder #(.HIDE_SHIFT(1'b0)) i_kbd_scan_decoder_pass (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .key_read(key_read), .key_ready(rdy_p), .key_code(code_p), .key_ext(ext_p),
        .key_rel(rel_p), .key_ascii(asc_p), .shift_on(sh_p));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic key(input logic [7:0] b, input bit out_h, input bit out_p,
                       input bit ext, input bit rel, input bit shift,
                       input logic [7:0] ascii, input string tag);
        item_t it;
        it = '{code: b, ext: ext, rel: rel, shift: shift, ascii: ascii};
        if (out_h) begin qh.push_back(it); th.push_back(tag); end
        if (out_p) begin qp.push_back(it); tp.push_back(tag); end
        send(b);
    endtask

    // Monitor: pops expected records as either instance presents them.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                key_read = 1'b0;
                if (rdy_h) begin
                    if (qh.size() == 0) check("unexpected record (hidden)", {24'h0, code_h}, 32'hFFFF);
                    else check(th.pop_front(), {13'h0, code_h, ext_h, rel_h, sh_h, asc_h},
                               {13'h0, qh.pop_front()});
                end
                if (rdy_p) begin
                    if (qp.size() == 0) check("unexpected record (pass)", {24'h0, code_p}, 32'hFFFF);
                    else check(tp.pop_front(), {13'h0, code_p, ext_p, rel_p, sh_p, asc_p},
                               {13'h0, qp.pop_front()});
                end
                if (rdy_h || rdy_p) key_read = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {30'h0, rdy_h, rdy_p}, 32'h0);
        check("R1 record", {14'h0, code_h, asc_h, ext_h, rel_h}, 32'h0);
        check("R1 shift", {30'h0, sh_h, sh_p}, 32'h0);

        mon_en = 1'b1;
        // R6 unshifted mapping
        key(8'h1C, 1, 1, 0, 0, 0, 8'h61, "R6 a");
        key(8'h16, 1, 1, 0, 0, 0, 8'h31, "R6 1");
        key(8'h5A, 1, 1, 0, 0, 0, 8'h0D, "R6 enter");
        key(8'h0D, 1, 1, 0, 0, 0, 8'h09, "R6 tab");
        key(8'h29, 1, 1, 0, 0, 0, 8'h20, "R6 space");
        key(8'h4E, 1, 1, 0, 0, 0, 8'h2D, "R6 minus");
        // R2 extended prefix, alt pair told apart by flag
        send(8'hE0);
        key(8'h11, 1, 1, 1, 0, 0, 8'h00, "R2 ext alt");
        key(8'h11, 1, 1, 0, 0, 0, 8'h00, "R2 ext cleared");
        // R3 break prefix
        send(8'hF0);
        key(8'h1C, 1, 1, 0, 1, 0, 8'h61, "R3 release a");
        key(8'h1C, 1, 1, 0, 0, 0, 8'h61, "R3 rel cleared");
        // R4 both prefixes
        send(8'hE0); send(8'hF0);
        key(8'h75, 1, 1, 1, 1, 0, 8'h00, "R4 ext+rel");
        // R9 hidden left shift make, status still visible
        key(8'h12, 0, 1, 0, 0, 1, 8'h00, "R9 shift pass");
        check("R9 hidden shift_on", {31'h0, sh_h}, 32'h1);
        // R7 shifted mapping
        key(8'h1C, 1, 1, 0, 0, 1, 8'h41, "R7 A");
        key(8'h16, 1, 1, 0, 0, 1, 8'h21, "R7 !");
        key(8'h4E, 1, 1, 0, 0, 1, 8'h5F, "R7 _");
        // R5 left/right shift combination
        key(8'h59, 0, 1, 0, 0, 1, 8'h00, "R5 right make");
        send(8'hF0);
        key(8'h12, 0, 1, 0, 1, 1, 8'h00, "R5 left break, right held");
        key(8'h15, 1, 1, 0, 0, 1, 8'h51, "R5 Q with right");
        send(8'hF0);
        key(8'h59, 0, 1, 0, 1, 0, 8'h00, "R5 right break");
        key(8'h15, 1, 1, 0, 0, 0, 8'h71, "R5 q");
        // R9 hidden shift still clears held flag
        send(8'hF0);
        key(8'h12, 0, 1, 0, 1, 0, 8'h00, "R9 hidden break");
        key(8'h1C, 1, 1, 0, 0, 0, 8'h61, "R9 flag cleared");
        // R5 extended 0x12 is not a shift key
        send(8'hE0);
        key(8'h12, 1, 1, 1, 0, 0, 8'h00, "R5 ext 12 shown");
        key(8'h1C, 1, 1, 0, 0, 0, 8'h61, "R5 ext 12 no shift");
        // R8 unmapped code
        key(8'h07, 1, 1, 0, 0, 0, 8'h00, "R8 unmapped");
        check("R8 queues drained", {qh.size(), qp.size()} != 0, 32'h0);

        // R10 / R11 handshake, driven directly
        mon_en = 1'b0;
        @(negedge clk);
        key_read = 1'b0;
        byte_valid = 1'b1; byte_data = 8'h1C;
        @(negedge clk);
        byte_valid = 1'b0;
        check("R11 record after one edge", {23'h0, rdy_h, code_h}, {23'h0, 1'b1, 8'h1C});
        repeat (5) @(negedge clk);
        check("R10 ready held", {23'h0, rdy_p, code_p}, {23'h0, 1'b1, 8'h1C});
        byte_valid = 1'b1; byte_data = 8'h32;
        @(negedge clk);
        byte_valid = 1'b0;
        check("R10 overwrite", {15'h0, rdy_h, code_h, asc_h}, {15'h0, 1'b1, 8'h32, 8'h62});
        byte_valid = 1'b1; byte_data = 8'h21; key_read = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0; key_read = 1'b0;
        check("R10 write wins over read", {23'h0, rdy_h, code_h}, {23'h0, 1'b1, 8'h21});
        key_read = 1'b1;
        @(negedge clk);
        key_read = 1'b0;
        check("R10 read clears", {30'h0, rdy_h, rdy_p}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule